// File: doc/BRIEF.md
# Periodic Wakeup Countdown Timer

This block is a down-counter that produces a periodic wakeup interrupt. Software supplies a 12-bit preset and picks one of four source tick rates: a 4096 Hz tick, a 64 Hz tick, a free-running 1 Hz tick that is not aligned to the seconds update, or the minute update strobe. Software then sets the enable bit. The first selected tick after enable loads the preset, and later ticks decrement the count. When the count would go from 1 to 0, the preset is reloaded on that same tick, so a count of 0 never appears while loaded. The same tick sets a sticky flag and starts an interrupt output that releases itself.

The interrupt output drops after one 4096 Hz tick when the 4096 Hz source is selected. For the other three sources it drops after 32 such ticks. The flag stays set until software clears it. A pause control holds the count without clearing it. A reload strobe writes the preset back into the counter, so periodic writes can serve as a watchdog restart.

Top module: `wkup_timer`

## Requirements
- R1: `src_sel` chooses the counting tick: 00 selects `tick_4k`, 01 selects `tick_64`, 10 selects `tick_1hz`, 11 selects `tick_min`. Pulses on the unselected tick inputs leave `count` unchanged.
- R2: While enabled and not yet loaded, `count` reads 0. The first selected tick after `enable` rises loads the preset into `count`, and that tick does not decrement.
- R3: Once loaded with `run`=1, each selected tick lowers `count` by exactly 1 while `count` is above 1.
- R4: A selected tick with `count`=1 reloads the preset instead of reaching 0, sets `flag` and raises `irq`, all on the same clock edge. While loaded, `count` is never 0.
- R5: `irq` falls on the edge of the Nth `tick_4k` after expiry. N is 1 when `src_sel`=00 and 32 otherwise. This release does not clear `flag`.
- R6: With `run`=0, selected ticks leave a loaded `count` unchanged. With `run`=1 again, counting resumes from the held value.
- R7: A one-cycle `reload_wr` strobe while enabled loads the preset into `count` and takes precedence over a tick in the same cycle. With `enable`=0 it has no effect.
- R8: `flag` is cleared only by a `flag_clr` strobe. If a clear and an expiry fall in the same cycle, `flag` ends up set.
- R9: Clearing `enable` returns `count` to 0 and drops `irq`, while `flag` keeps its value. A later enable again loads the preset on the first selected tick.
- R10: A preset of 0 counts as 4096, so `count` loads the value 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_4k | input | 1 | One-cycle 4096 Hz tick, also the release timebase |
| tick_64 | input | 1 | One-cycle 64 Hz tick |
| tick_1hz | input | 1 | One-cycle free-running 1 Hz tick |
| tick_min | input | 1 | One-cycle minute update strobe |
| src_sel | input | 2 | Source tick select |
| preset | input | 12 | Preset count, where 0 means 4096 |
| enable | input | 1 | Timer enable |
| run | input | 1 | 1 = count, 0 = hold |
| reload_wr | input | 1 | One-cycle strobe that reloads the preset |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| count | output | 13 | Current count (0 before the first load) |
| flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Self-releasing interrupt, active high |

## Verification
The countdown is driven on the 64 Hz source with a short preset. This separates the load tick from the decrement ticks and shows the reload on expiry. The same sequence is repeated on the 4096 Hz source, where one tick both counts and times the release. The slow and fast release lengths are therefore told apart by counting 4096 Hz ticks. Pulses on the unselected tick inputs, paused ticks and reload strobes with the timer disabled must all leave the count untouched. A clear that arrives together with an expiry, a preset of 0, and a disable followed by a re-enable cover the boundary and priority cases.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    parameter int PRESET_W  = 12;
    parameter int COUNT_W   = PRESET_W + 1;
    parameter int REL_FAST  = 1;
    parameter int REL_SLOW  = 32;
    parameter int REL_W     = $clog2(REL_SLOW + 1);
    parameter int NUM_SRC   = 4;
    parameter int SEL_W     = $clog2(NUM_SRC);

    typedef struct packed {
        logic               loaded;
        logic [COUNT_W-1:0] value;
    } ctr_state_t;

    typedef struct packed {
        logic             flag;
        logic             irq;
        logic [REL_W-1:0] rel;
    } irq_state_t;

    function automatic logic [COUNT_W-1:0] preset_eff(input logic [PRESET_W-1:0] p);
        if (p == '0) return COUNT_W'(1) << PRESET_W;
        return COUNT_W'(p);
    endfunction
endpackage

// File: rtl/wkt_src_mux.sv
module wkt_src_mux
    import wkt_pkg::*;
(
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick_sel,
    output logic               fast_src
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = ticks[i] && (sel == SEL_W'(i));
    end

    assign tick_sel = |hit;
    assign fast_src = (sel == '0);

    always_comb begin
        assert (!$isunknown(sel) -> $onehot0(hit));   // r1: at most one source passes
    end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter
    import wkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                run,
    input  logic                tick,
    input  logic                reload_wr,
    input  logic [PRESET_W-1:0] preset,
    output logic [COUNT_W-1:0]  count,
    output logic                expire
);
    ctr_state_t st_d, st_q;
    logic [COUNT_W-1:0] load_val;

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        load_val = preset_eff(preset);
        if (!enable) begin
            st_d = '0;
        end else if (reload_wr) begin
            st_d.loaded = 1'b1;
            st_d.value  = load_val;
        end else if (tick) begin
            if (!st_q.loaded) begin
                st_d.loaded = 1'b1;
                st_d.value  = load_val;
            end else if (run) begin
                if (st_q.value == COUNT_W'(1)) begin
                    st_d.value = load_val;
                    expire     = 1'b1;
                end else begin
                    st_d.value = st_q.value - COUNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.value;

    p_never_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loaded |-> st_q.value != '0);
    p_hold_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.loaded && !run && !reload_wr) |=> $stable(st_q.value));
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.value == '0 && !st_q.loaded));
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.loaded && run && tick && !reload_wr && st_q.value > COUNT_W'(1))
        |=> st_q.value == $past(st_q.value) - COUNT_W'(1));
endmodule

// File: rtl/wkt_irq.sv
module wkt_irq
    import wkt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic expire,
    input  logic fast_src,
    input  logic tick_4k,
    input  logic flag_clr,
    output logic flag,
    output logic irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.irq && tick_4k) begin
            if (st_q.rel <= REL_W'(1)) begin
                st_d.irq = 1'b0;
                st_d.rel = '0;
            end else begin
                st_d.rel = st_q.rel - REL_W'(1);
            end
        end
        if (expire) begin
            st_d.irq = 1'b1;
            st_d.rel = fast_src ? REL_W'(REL_FAST) : REL_W'(REL_SLOW);
        end
        if (!enable) begin
            st_d.irq = 1'b0;
            st_d.rel = '0;
        end
        if (flag_clr) st_d.flag = 1'b0;
        if (expire)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.irq;

    p_expire_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag && irq));
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    p_irq_off_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq);
    p_irq_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !tick_4k && enable) |=> irq);
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
    import wkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_4k,
    input  logic                tick_64,
    input  logic                tick_1hz,
    input  logic                tick_min,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic [PRESET_W-1:0] preset,
    input  logic                enable,
    input  logic                run,
    input  logic                reload_wr,
    input  logic                flag_clr,
    output logic [COUNT_W-1:0]  count,
    output logic                flag,
    output logic                irq
);
    logic tick_sel, fast_src, expire;

    wkt_src_mux u_mux (
        .ticks    ({tick_min, tick_1hz, tick_64, tick_4k}),
        .sel      (src_sel),
        .tick_sel (tick_sel),
        .fast_src (fast_src)
    );

    wkt_counter u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .tick      (tick_sel),
        .reload_wr (reload_wr),
        .preset    (preset),
        .count     (count),
        .expire    (expire)
    );

    wkt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .expire   (expire),
        .fast_src (fast_src),
        .tick_4k  (tick_4k),
        .flag_clr (flag_clr),
        .flag     (flag),
        .irq      (irq)
    );
endmodule

// File: tb/wkup_timer_test.sv
module wkup_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_4k = 0, tick_64 = 0, tick_1hz = 0, tick_min = 0;
    logic [1:0]  src_sel = 2'b01;
    logic [11:0] preset = 12'd3;
    logic        enable = 0, run = 1, reload_wr = 0, flag_clr = 0;
    logic [12:0] count;
    logic        flag, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wkup_timer uut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one-cycle pulses on the chosen inputs, sample at the following negedge
    task automatic pulse(bit t4, bit t64, bit t1, bit tm, bit rl = 0, bit fc = 0);
        @(negedge clk);
        tick_4k = t4; tick_64 = t64; tick_1hz = t1; tick_min = tm;
        reload_wr = rl; flag_clr = fc;
        @(negedge clk);
        tick_4k = 0; tick_64 = 0; tick_1hz = 0; tick_min = 0;
        reload_wr = 0; flag_clr = 0;
    endtask

    task automatic restart(logic [1:0] sel, logic [11:0] p);
        @(negedge clk); enable = 0; flag_clr = 1;
        @(negedge clk); flag_clr = 0; src_sel = sel; preset = p; run = 1; enable = 1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R2 reset count", count, 0);
        check("R8 reset flag", flag, 0);
        check("R5 reset irq", irq, 0);
    endtask

    task automatic t_basic;
        restart(2'b01, 12'd3);
        check("R2 unloaded count", count, 0);
        pulse(0, 1, 0, 0); check("R2 first tick loads", count, 3);
        pulse(0, 1, 0, 0); check("R3 decrement", count, 2);
        pulse(1, 0, 1, 1); check("R1 unselected ignored", count, 2);
        pulse(0, 1, 0, 0); check("R3 decrement to 1", count, 1);
        check("R4 no flag yet", flag, 0);
        pulse(0, 1, 0, 0); check("R4 reload not zero", count, 3);
        check("R4 flag set", flag, 1);
        check("R4 irq set", irq, 1);
    endtask

    task automatic t_slow_release;
        // continues from t_basic: irq active on 64 Hz source
        for (int i = 0; i < 31; i++) pulse(1, 0, 0, 0);
        check("R5 slow irq held 31", irq, 1);
        pulse(1, 0, 0, 0);
        check("R5 slow irq released 32", irq, 0);
        check("R5 flag kept", flag, 1);
        check("R1 4k ignored for count", count, 3);
    endtask

    task automatic t_fast;
        restart(2'b00, 12'd2);
        pulse(1, 0, 0, 0); check("R2 load fast", count, 2);
        pulse(1, 0, 0, 0); check("R3 fast dec", count, 1);
        pulse(1, 0, 0, 0); check("R4 fast expire", count, 2);
        check("R5 fast irq on", irq, 1);
        pulse(1, 0, 0, 0); check("R5 fast irq off", irq, 0);
        check("R3 fast count", count, 1);
    endtask

    task automatic t_pause_reload;
        restart(2'b10, 12'd5);
        pulse(0, 0, 1, 0); check("R1 1hz load", count, 5);
        pulse(0, 0, 1, 0); check("R1 1hz dec", count, 4);
        @(negedge clk) run = 0;
        pulse(0, 0, 1, 0); pulse(0, 0, 1, 0);
        check("R6 hold paused", count, 4);
        @(negedge clk) run = 1;
        pulse(0, 0, 1, 0); check("R6 resume", count, 3);
        pulse(0, 0, 1, 0, 1); check("R7 reload wins over tick", count, 5);
        pulse(0, 0, 1, 0); check("R7 after reload", count, 4);
        @(negedge clk) enable = 0;
        pulse(0, 0, 0, 0, 1); check("R7 reload ignored disabled", count, 0);
    endtask

    task automatic t_flag_race;
        restart(2'b11, 12'd1);
        pulse(0, 0, 0, 1); check("R1 minute load", count, 1);
        pulse(0, 0, 0, 1); check("R4 preset1 expire", flag, 1);
        pulse(0, 0, 0, 0, 0, 1); check("R8 clear", flag, 0);
        pulse(0, 0, 0, 1, 0, 1); check("R8 set wins", flag, 1);
        check("R4 preset1 count", count, 1);
    endtask

    task automatic t_zero_disable;
        restart(2'b01, 12'd0);
        pulse(0, 1, 0, 0); check("R10 zero means 4096", count, 4096);
        pulse(0, 1, 0, 0); check("R10 4096 dec", count, 4095);
        @(negedge clk) preset = 12'd7; flag_clr = 1;
        @(negedge clk) flag_clr = 0;
        pulse(0, 0, 0, 0, 1); check("R7 reload", count, 7);
        @(negedge clk) enable = 0;
        @(negedge clk); check("R9 disabled count", count, 0);
        check("R9 disabled irq", irq, 0);
        @(negedge clk) enable = 1;
        pulse(0, 1, 0, 0); check("R9 reenable load", count, 7);
    endtask

    task automatic t_disable_irq;
        restart(2'b01, 12'd1);
        pulse(0, 1, 0, 0); pulse(0, 1, 0, 0);
        check("R4 irq before disable", irq, 1);
        @(negedge clk) enable = 0;
        @(negedge clk); check("R9 irq dropped", irq, 0);
        check("R9 flag kept", flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_slow_release();
        t_fast();
        t_pause_reload();
        t_flag_race();
        t_zero_disable();
        t_disable_irq();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule